// File: doc/BRIEF.md
# Cache Access Policy Classifier

This block sits after the tag lookup of a data cache and tells the rest of the memory pipeline what to do with each load or store. For every accepted request it looks at the translation enable, the cache enable, the page's cacheable and write-allocate attributes, the access direction and size, and the hit result. It then produces one decision: return data from the cache, update the cache, fetch a whole line, or issue an uncached external transaction. An uncached transaction carries exactly the bytes of the access, with an address aligned to the access size and byte-lane enables.

A disabled cache is still looked up. A hit in a disabled cache is served as normal. A miss in a disabled cache never starts a line fill, even when translation is on and the page is cacheable.

Both sides use a valid/ready handshake. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. A decision leaves on an edge where `dec_valid` and `dec_ready` are both high. While `dec_ready` is low, a pending decision stays on the outputs unchanged. There is one register stage, and the block accepts a new request in the same cycle that the pending decision drains.

Top module: `cache_policy_sorter`

## Requirements
- R1: An access counts as cacheable only when `req_mmu_on`, `req_cache_on` and `req_page_cacheable` are all 1. A load miss with any of the three at 0 is sent as an uncached read.
- R2: A load hit yields kind 0 (serve from cache), whatever the enables are. It carries `dec_len` 0, `dec_be` 0, and `dec_addr` equal to the request address.
- R3: A store hit yields kind 1 (write into cache), whatever the enables are. It carries `dec_len` 0, `dec_be` 0, and `dec_addr` equal to the request address.
- R4: When `req_cache_on` is 0, a miss never yields kind 2 (line fill).
- R5: A cacheable load miss yields kind 2. It carries `dec_len` equal to LINE_BYTES (32), `dec_addr` with its low log2(LINE_BYTES) bits cleared, and `dec_be` 0.
- R6: A load miss that is not cacheable yields kind 3 (uncached read). Its `dec_len` is the access size: size code 0 gives 1 byte, code 1 gives 2 bytes, and codes 2 and 3 give 4 bytes. `dec_addr` has its low log2(len) bits cleared.
- R7: A store miss yields kind 2 only when the access is cacheable and `req_page_walloc` is 1.
- R8: Any other store miss yields kind 4 (uncached write), with the same length and alignment rules as R6.
- R9: For kinds 3 and 4, `dec_be` has a 1 for each byte lane the access covers:
  - bit `addr[1:0]` for a byte;
  - `4'b0011` shifted left by `2*addr[1]` for a halfword;
  - `4'b1111` for a word.
- R10: Decisions leave in request order, one per accepted request. `req_ready` is high whenever no decision is held or `dec_ready` is high.
- R11: While `dec_valid` is 1 and `dec_ready` is 0, every `dec_*` output keeps its value into the next cycle.
- R12: During and right after reset, `dec_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_mmu_on | input | 1 | Address translation enabled |
| req_cache_on | input | 1 | Data cache enabled |
| req_page_cacheable | input | 1 | Page cacheable attribute |
| req_page_walloc | input | 1 | Page write-allocate attribute |
| req_is_store | input | 1 | 1 for a store, 0 for a load |
| req_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| req_addr | input | ADDR_W | Access byte address |
| req_hit | input | 1 | Tag lookup hit |
| dec_valid | output | 1 | Decision present |
| dec_ready | input | 1 | Downstream takes the decision |
| dec_kind | output | 3 | 0 serve, 1 cache write, 2 line fill, 3 uncached read, 4 uncached write |
| dec_len | output | LEN_W | External request length in bytes (0 for hits) |
| dec_addr | output | ADDR_W | External or lookup address, aligned per kind |
| dec_be | output | BUS_BYTES | Byte-lane enables for uncached kinds |

## Verification
Some checks run on every cycle. These cover:
- holding the output stable under back-pressure;
- the ready rule;
- keeping hits out of external requests;
- never filling on a miss that is not cacheable;
- the length and line alignment of every fill;
- a single lane for byte transfers.

Other properties need the bench's scenarios. Its scoreboard walks every combination of enables, attributes, direction, hit and size, at random addresses and under random stalls. That is the only way to show that each decision matches the exact kind, length, aligned address and lane mask, and that decisions stay in order with none lost.

// File: rtl/cpol_pkg.sv
package cpol_pkg;
  typedef enum logic [2:0] {
    K_HIT_LOAD  = 3'd0,
    K_HIT_STORE = 3'd1,
    K_FILL      = 3'd2,
    K_UNC_READ  = 3'd3,
    K_UNC_WRITE = 3'd4
  } cpol_kind_e;
endpackage

// File: rtl/cpol_classify.sv
module cpol_classify
  import cpol_pkg::*;
(
  input  logic       mmu_on,
  input  logic       cache_on,
  input  logic       page_cacheable,
  input  logic       page_walloc,
  input  logic       is_store,
  input  logic       hit,
  output cpol_kind_e kind
);
  logic cacheable;

  // All three conditions must hold for an access to be cacheable.
  assign cacheable = mmu_on & cache_on & page_cacheable;

  always_comb begin
    if (hit) begin
      // Hits are served even when the cache is disabled.
      kind = is_store ? K_HIT_STORE : K_HIT_LOAD;
    end else if (!is_store) begin
      kind = cacheable ? K_FILL : K_UNC_READ;
    end else begin
      kind = (cacheable && page_walloc) ? K_FILL : K_UNC_WRITE;
    end
  end
endmodule

// File: rtl/cpol_lane.sv
module cpol_lane
  import cpol_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int BUS_BYTES  = 4,
  parameter int LINE_BYTES = 32,
  localparam int LEN_W     = $clog2(LINE_BYTES) + 1
) (
  input  cpol_kind_e         kind,
  input  logic [1:0]         size,
  input  logic [ADDR_W-1:0]  addr,
  output logic [LEN_W-1:0]   len,
  output logic [ADDR_W-1:0]  addr_out,
  output logic [BUS_BYTES-1:0] be
);
  localparam int MAX_LOG = $clog2(BUS_BYTES);
  localparam int LOFF_W  = $clog2(LINE_BYTES);

  int sz_log;
  int nbytes;
  int lane_off;

  always_comb begin
    sz_log   = (int'(size) > MAX_LOG) ? MAX_LOG : int'(size);
    nbytes   = 1 << sz_log;
    lane_off = 0;
    for (int i = 0; i < MAX_LOG; i++) begin
      if (i >= sz_log && addr[i]) lane_off += (1 << i);
    end

    len      = '0;
    addr_out = addr;
    be       = '0;
    unique case (kind)
      K_FILL: begin
        len = LEN_W'(LINE_BYTES);
        for (int i = 0; i < LOFF_W; i++) addr_out[i] = 1'b0;
      end
      K_UNC_READ, K_UNC_WRITE: begin
        len = LEN_W'(nbytes);
        for (int i = 0; i < MAX_LOG; i++) begin
          if (i < sz_log) addr_out[i] = 1'b0;
        end
        for (int i = 0; i < BUS_BYTES; i++) begin
          be[i] = (i >= lane_off) && (i < lane_off + nbytes);
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/cpol_stage.sv
module cpol_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end
endmodule

// File: rtl/cache_policy_sorter.sv
module cache_policy_sorter
  import cpol_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int BUS_BYTES  = 4,
  parameter int LINE_BYTES = 32,
  localparam int LEN_W     = $clog2(LINE_BYTES) + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_mmu_on,
  input  logic                 req_cache_on,
  input  logic                 req_page_cacheable,
  input  logic                 req_page_walloc,
  input  logic                 req_is_store,
  input  logic [1:0]           req_size,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic                 req_hit,
  output logic                 dec_valid,
  input  logic                 dec_ready,
  output logic [2:0]           dec_kind,
  output logic [LEN_W-1:0]     dec_len,
  output logic [ADDR_W-1:0]    dec_addr,
  output logic [BUS_BYTES-1:0] dec_be
);
  localparam int PW = 3 + LEN_W + ADDR_W + BUS_BYTES;

  cpol_kind_e            kind_c;
  logic [LEN_W-1:0]      len_c;
  logic [ADDR_W-1:0]     addr_c;
  logic [BUS_BYTES-1:0]  be_c;
  logic [PW-1:0]         pay_in;
  logic [PW-1:0]         pay_out;

  cpol_classify u_cls (
    .mmu_on         (req_mmu_on),
    .cache_on       (req_cache_on),
    .page_cacheable (req_page_cacheable),
    .page_walloc    (req_page_walloc),
    .is_store       (req_is_store),
    .hit            (req_hit),
    .kind           (kind_c)
  );

  cpol_lane #(
    .ADDR_W     (ADDR_W),
    .BUS_BYTES  (BUS_BYTES),
    .LINE_BYTES (LINE_BYTES)
  ) u_lane (
    .kind     (kind_c),
    .size     (req_size),
    .addr     (req_addr),
    .len      (len_c),
    .addr_out (addr_c),
    .be       (be_c)
  );

  assign pay_in = {kind_c, len_c, addr_c, be_c};

  cpol_stage #(.W(PW)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (req_valid),
    .in_ready  (req_ready),
    .in_data   (pay_in),
    .out_valid (dec_valid),
    .out_ready (dec_ready),
    .out_data  (pay_out)
  );

  assign {dec_kind, dec_len, dec_addr, dec_be} = pay_out;
endmodule

// File: rtl/cpol_checker.sv
module cpol_checker #(
  parameter int ADDR_W     = 32,
  parameter int BUS_BYTES  = 4,
  parameter int LINE_BYTES = 32,
  localparam int LEN_W     = $clog2(LINE_BYTES) + 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic                 req_ready,
  input logic                 req_mmu_on,
  input logic                 req_cache_on,
  input logic                 req_page_cacheable,
  input logic                 req_is_store,
  input logic                 req_hit,
  input logic                 dec_valid,
  input logic                 dec_ready,
  input logic [2:0]           dec_kind,
  input logic [LEN_W-1:0]     dec_len,
  input logic [ADDR_W-1:0]    dec_addr,
  input logic [BUS_BYTES-1:0] dec_be
);
  localparam int LOFF_W = $clog2(LINE_BYTES);

  logic take;
  assign take = req_valid && req_ready;

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !dec_ready) |=> (dec_valid && $stable(dec_kind) && $stable(dec_len)
                                   && $stable(dec_addr) && $stable(dec_be)));

  p_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!dec_valid || dec_ready) |-> req_ready);

  p_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> dec_valid);

  p_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (take && req_hit) |=> (dec_kind == (req_is_store ? 3'd1 : 3'd0) || $past(req_is_store) != req_is_store
                           ? (dec_kind <= 3'd1 && dec_len == '0) : (dec_kind <= 3'd1 && dec_len == '0)));

  p_nofill_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !req_hit && !(req_mmu_on && req_cache_on && req_page_cacheable)) |=> (dec_kind != 3'd2));

  p_fill_shape_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_kind == 3'd2) |-> (dec_len == LEN_W'(LINE_BYTES) && dec_addr[LOFF_W-1:0] == '0 && dec_be == '0));

  p_byte_lane_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_kind >= 3'd3 && dec_len == LEN_W'(1)) |-> ($countones(dec_be) == 1));
endmodule

bind cache_policy_sorter cpol_checker #(
  .ADDR_W     (ADDR_W),
  .BUS_BYTES  (BUS_BYTES),
  .LINE_BYTES (LINE_BYTES)
) u_chk (
  .clk                (clk),
  .rst_n              (rst_n),
  .req_valid          (req_valid),
  .req_ready          (req_ready),
  .req_mmu_on         (req_mmu_on),
  .req_cache_on       (req_cache_on),
  .req_page_cacheable (req_page_cacheable),
  .req_is_store       (req_is_store),
  .req_hit            (req_hit),
  .dec_valid          (dec_valid),
  .dec_ready          (dec_ready),
  .dec_kind           (dec_kind),
  .dec_len            (dec_len),
  .dec_addr           (dec_addr),
  .dec_be             (dec_be)
);

// File: tb/cache_policy_sorter_tb.sv
module cache_policy_sorter_tb;
  localparam int AW = 32;
  localparam int BB = 4;
  localparam int LB = 32;
  localparam int LW = 6;
  localparam int EW = 3 + LW + AW + BB;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic req_mmu_on = 1'b0, req_cache_on = 1'b0, req_page_cacheable = 1'b0;
  logic req_page_walloc = 1'b0, req_is_store = 1'b0, req_hit = 1'b0;
  logic [1:0] req_size = '0;
  logic [AW-1:0] req_addr = '0;
  logic dec_valid;
  logic dec_ready = 1'b0;
  logic [2:0] dec_kind;
  logic [LW-1:0] dec_len;
  logic [AW-1:0] dec_addr;
  logic [BB-1:0] dec_be;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [EW-1:0] sb[$];

  always #10 clk = ~clk;

  cache_policy_sorter u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_mmu_on(req_mmu_on), .req_cache_on(req_cache_on),
    .req_page_cacheable(req_page_cacheable), .req_page_walloc(req_page_walloc),
    .req_is_store(req_is_store), .req_size(req_size), .req_addr(req_addr),
    .req_hit(req_hit), .dec_valid(dec_valid), .dec_ready(dec_ready),
    .dec_kind(dec_kind), .dec_len(dec_len), .dec_addr(dec_addr), .dec_be(dec_be)
  );

  // Reference decision from the requirements.
  function automatic logic [EW-1:0] model(input logic m, input logic c, input logic p,
                                          input logic w, input logic st, input logic h,
                                          input logic [1:0] sz, input logic [AW-1:0] a);
    logic [2:0] k;
    logic [LW-1:0] ln;
    logic [AW-1:0] ao;
    logic [BB-1:0] be;
    logic cach;
    int nb;
    cach = m & c & p;                 // R1
    nb = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    ao = a; ln = '0; be = '0;
    if (h) k = st ? 3'd1 : 3'd0;      // R2, R3
    else if (!st) k = cach ? 3'd2 : 3'd3;           // R5, R6, R4
    else k = (cach && w) ? 3'd2 : 3'd4;             // R7, R8
    if (k == 3'd2) begin
      ln = LW'(LB);
      ao[4:0] = 5'd0;
    end else if (k >= 3'd3) begin
      ln = LW'(nb);
      if (nb == 1) be = 4'b0001 << a[1:0];          // R9
      else if (nb == 2) begin be = 4'b0011 << (2 * a[1]); ao[0] = 1'b0; end
      else begin be = 4'b1111; ao[1:0] = 2'b00; end
    end
    return {k, ln, ao, be};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [EW-1:0] act,
                       input logic [EW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send(input logic m, input logic c, input logic p, input logic w,
                      input logic st, input logic h, input logic [1:0] sz,
                      input logic [AW-1:0] a);
    @(negedge clk);
    #2;
    req_valid = 1'b1; req_mmu_on = m; req_cache_on = c; req_page_cacheable = p;
    req_page_walloc = w; req_is_store = st; req_hit = h; req_size = sz; req_addr = a;
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #3;
    end
    sb.push_back(model(m, c, p, w, st, h, sz, a));
  endtask

  task automatic idle();
    @(negedge clk);
    #2;
    req_valid = 1'b0;
  endtask

  // Monitor: set ready, then compare the decision about to leave.
  bit ready_random = 1'b1;
  bit was_stalled = 1'b0;
  logic [EW-1:0] held;
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (was_stalled)
          check({dec_kind, dec_len, dec_addr, dec_be} == held && dec_valid, "R11",
                {dec_kind, dec_len, dec_addr, dec_be}, held);
        dec_ready = ready_random ? (($urandom % 4) != 0) : 1'b1;
        #1;
        if (dec_valid && dec_ready) begin
          logic [EW-1:0] act;
          logic [EW-1:0] exp;
          string tag;
          act = {dec_kind, dec_len, dec_addr, dec_be};
          if (sb.size() == 0) begin
            check(1'b0, "R10 extra decision", act, '0);
          end else begin
            exp = sb.pop_front();
            case (exp[EW-1 -: 3])
              3'd0: tag = "R2";
              3'd1: tag = "R3";
              3'd2: tag = "R5/R7";
              3'd3: tag = "R6";
              default: tag = "R8";
            endcase
            check(act == exp, tag, act, exp);
          end
        end
        was_stalled = dec_valid && !dec_ready;
        held = {dec_kind, dec_len, dec_addr, dec_be};
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(dec_valid == 1'b0, "R12", {{(EW-1){1'b0}}, dec_valid}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check(dec_valid == 1'b0 && req_ready == 1'b1, "R12",
          {{(EW-2){1'b0}}, dec_valid, req_ready}, {{(EW-1){1'b0}}, 1'b1});

    // Directed: disabled cache hit serves (R2), disabled miss never fills (R4).
    send(1, 0, 1, 1, 0, 1, 2'd2, 32'h0000_1004);
    send(1, 0, 1, 1, 0, 0, 2'd2, 32'h0000_1004);
    send(1, 0, 1, 1, 1, 0, 2'd1, 32'h0000_1006);
    // Byte lane walk (R9) and store hit in disabled cache (R3).
    for (int i = 0; i < 4; i++) send(0, 1, 1, 0, 1, 0, 2'd0, 32'h0000_2000 + i);
    send(0, 0, 0, 0, 1, 1, 2'd0, 32'h0000_2003);
    idle();

    // Exhaustive sweep of attributes, direction, hit and size (R1, R5..R8).
    for (int c = 0; c < 64; c++) begin
      for (int s = 0; s < 4; s++) begin
        send(c[0], c[1], c[2], c[3], c[4], c[5], 2'(s), $urandom);
        if ((c + s) % 7 == 0) idle();
      end
    end

    // Back-to-back at full throughput (R10).
    ready_random = 1'b0;
    for (int i = 0; i < 16; i++) send(1, 1, 1, 1, i[0], 0, 2'(i), $urandom);
    idle();

    repeat (40) @(negedge clk);
    check(sb.size() == 0, "R10 drained", EW'(sb.size()), '0);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule